// File: doc/BRIEF.md
# Infrared serial bit-cell codec

This block sits between the serial lines of a UART and an infrared transceiver. On the transmit side it watches the UART output line, one bit cell at a time. A cell carrying 0 becomes a single short high pulse on the IR output. A cell carrying 1 leaves the IR output low. Start, data and stop bits all follow this one rule, so every frame opens with a pulse and closes with a pulse-free stop cell. Bit cells are timed by a 16x oversampling tick from an external baud generator. A cell begins on the first tick at which the UART line is seen low. Later cells follow back to back every 16 ticks for as long as zeros keep arriving.

The pulse width comes from a 3-bit select field. Code 0 gives a pulse of 3 ticks, which is 3/16 of a bit cell. Codes 1 to 7 give fixed widths of code × `UNIT_CYC` system clocks. With `UNIT_CYC` = 8 and a 20 MHz clock, code 4 yields 32 clocks, about 1.6 µs. The select value is captured when each pulse starts.

On the receive side the IR input passes through a two-flop synchronizer followed by a rising-edge detector. Any accepted rising edge, however short the pulse, pulls the recovered UART line low for a 16-tick window. Another edge inside the window restarts it. When a half-duplex control input is high and the transmitter is busy, receive edges are ignored, so the block's own echo is never decoded.

Transmit states:
- `TX_IDLE` moves to `TX_PULSE` on a tick with the UART line low.
- `TX_PULSE` moves to `TX_GAP` when the width has elapsed.
- At the end of a cell, `TX_PULSE` and `TX_GAP` return to `TX_PULSE` if the next cell is 0, or to `TX_IDLE` if it is 1.

Receive states:
- `RX_IDLE` moves to `RX_HOLD` on an accepted edge.
- `RX_HOLD` returns to `RX_IDLE` after 16 ticks with no new edge.

Top module: `ir_sir_codec`

## Requirements
- R1: While reset is asserted and right after it, `ir_txd` is 0 and `uart_rxd` is 1.
- R2: A cell carrying 0 produces exactly one rising edge on `ir_txd`. The edge appears on the clock edge at which the cell's first tick samples `uart_txd` low.
- R3: A cell carrying 1 produces no pulse, so each frame has as many pulses as it has zero bits, including the start bit.
- R4: With `width_sel` = 3'b000, each pulse lasts exactly 3 tick periods (3/16 of the cell).
- R5: With `width_sel` = k in 1..7, each pulse lasts exactly k × `UNIT_CYC` system clocks (8k clocks by default).
- R6: A rising edge on `ir_rxd` drives `uart_rxd` low on the third clock edge after it. The line stays low for 16 ticks counted from that edge, then returns to 1.
- R7: A receive pulse only one clock wide is still decoded as a 0.
- R8: A second rising edge on `ir_rxd` during the low window restarts the full 16-tick window.
- R9: With `half_duplex` = 1, receive edges that arrive while the transmitter is busy leave `uart_rxd` at 1.
- R10: With `half_duplex` = 0 and `ir_txd` looped back to `ir_rxd`, `uart_rxd` at mid-cell equals the transmitted bit for every cell of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-clock strobe at 16 times the bit rate |
| uart_txd | input | 1 | Serial output of the UART to be encoded |
| width_sel | input | 3 | Pulse width code: 0 = 3/16 of a cell, k = k × UNIT_CYC clocks |
| half_duplex | input | 1 | When 1, receive is blanked while transmitting |
| ir_rxd | input | 1 | Raw pulse input from the IR receiver |
| ir_txd | output | 1 | Active-high pulse output to the IR emitter |
| uart_rxd | output | 1 | Recovered serial line for the UART receiver |

## Verification
A transmit pulse appears one clock after the tick that samples a low cell. Its fall follows exactly 3 tick periods or k × 8 clocks later. The bench records the rising and falling edge cycles of `ir_txd` in a monitor, then compares them with the frame start plus 64 clocks per cell plus one. A receive edge shows on `uart_rxd` after three clock edges, so the bench checks for 1 at two clocks and for 0 at three. Because the 16-tick window has a one-tick phase uncertainty, the line is checked low at 63 clocks and high at 68, and loopback frames are sampled at the middle of each 64-clock cell.

// File: rtl/ir_sir_pkg.sv
package ir_sir_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_PULSE = 2'd1,
        TX_GAP   = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_HOLD = 1'b1
    } rx_state_e;

    // Fixed-mode pulse length in system clocks for a nonzero width code.
    function automatic int unsigned fixed_pulse_cycles(input int unsigned unit,
                                                       input int unsigned code);
        return unit * code;
    endfunction

endpackage

// File: rtl/ir_sir_tx_enc.sv
module ir_sir_tx_enc
    import ir_sir_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3,
    parameter int UNIT_CYC      = 8,
    parameter int SEL_W         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             uart_txd,
    input  logic [SEL_W-1:0] width_sel,
    output logic             ir_txd,
    output logic             tx_busy
);
    localparam int PH_W    = $clog2(TICKS_PER_BIT);
    localparam int MAX_CYC = UNIT_CYC * ((1 << SEL_W) - 1);
    localparam int DC_W    = $clog2(MAX_CYC + 1);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(TICKS_PER_BIT - 1);
    localparam logic [PH_W-1:0] PH_PEND  = PH_W'(PULSE_TICKS - 1);

    tx_state_e        state_q, state_d;
    logic [PH_W-1:0]  phase_q, phase_d;
    logic [DC_W-1:0]  dcnt_q, dcnt_d;
    logic [SEL_W-1:0] sel_q, sel_d;
    logic             cell_end;
    logic [DC_W-1:0]  dc_load;

    assign cell_end = tick16 && (phase_q == PH_LAST);
    assign dc_load  = DC_W'(fixed_pulse_cycles(UNIT_CYC, 32'(width_sel)) - 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            phase_q <= '0;
            dcnt_q  <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            dcnt_q  <= dcnt_d;
            sel_q   <= sel_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        dcnt_d  = dcnt_q;
        sel_d   = sel_q;
        unique case (state_q)
            TX_IDLE: begin
                if (tick16 && !uart_txd) begin
                    state_d = TX_PULSE;
                    phase_d = '0;
                    sel_d   = width_sel;
                    dcnt_d  = dc_load;
                end
            end
            TX_PULSE, TX_GAP: begin
                if (tick16) phase_d = phase_q + 1'b1;
                if (cell_end) begin
                    if (!uart_txd) begin
                        state_d = TX_PULSE;
                        phase_d = '0;
                        sel_d   = width_sel;
                        dcnt_d  = dc_load;
                    end else begin
                        state_d = TX_IDLE;
                    end
                end else if (state_q == TX_PULSE) begin
                    if (sel_q == '0) begin
                        if (tick16 && phase_q == PH_PEND) state_d = TX_GAP;
                    end else if (dcnt_q == '0) begin
                        state_d = TX_GAP;
                    end else begin
                        dcnt_d = dcnt_q - 1'b1;
                    end
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ir_txd  = (state_q == TX_PULSE);
        tx_busy = (state_q != TX_IDLE);
    end

    // R2
    tx_rise_on_low_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_txd) |-> ($past(tick16) && !$past(uart_txd)));

    // R4
    quarter_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ir_txd) && ($past(sel_q) == '0)) |-> $past(tick16));

endmodule

// File: rtl/ir_sir_sync.sv
module ir_sir_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] && !prev;

endmodule

// File: rtl/ir_sir_rx_dec.sv
module ir_sir_rx_dec
    import ir_sir_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic ir_rise,
    input  logic half_duplex,
    input  logic tx_busy,
    output logic uart_rxd
);
    localparam int PH_W = $clog2(TICKS_PER_BIT);
    localparam logic [PH_W-1:0] CNT_LAST = PH_W'(TICKS_PER_BIT - 1);

    rx_state_e       state_q, state_d;
    logic [PH_W-1:0] cnt_q, cnt_d;
    logic            edge_ok;

    assign edge_ok = ir_rise && !(half_duplex && tx_busy);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RX_IDLE: begin
                if (edge_ok) begin
                    state_d = RX_HOLD;
                    cnt_d   = '0;
                end
            end
            RX_HOLD: begin
                if (edge_ok) begin
                    cnt_d = '0;
                end else if (tick16) begin
                    if (cnt_q == CNT_LAST) state_d = RX_IDLE;
                    else                   cnt_d   = cnt_q + 1'b1;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // Outputs
    always_comb uart_rxd = (state_q != RX_HOLD);

    // R6
    rx_fall_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uart_rxd) |-> $past(ir_rise));

    // R8
    rx_edge_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_rise && !(half_duplex && tx_busy)) |=> !uart_rxd);

    // R9
    rx_echo_blanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_rise && half_duplex && tx_busy && uart_rxd) |=> uart_rxd);

endmodule

// File: rtl/ir_sir_codec.sv
module ir_sir_codec #(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3,
    parameter int UNIT_CYC      = 8,
    parameter int SEL_W         = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             uart_txd,
    input  logic [SEL_W-1:0] width_sel,
    input  logic             half_duplex,
    input  logic             ir_rxd,
    output logic             ir_txd,
    output logic             uart_rxd
);
    logic tx_busy;
    logic ir_rise;

    ir_sir_tx_enc #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .PULSE_TICKS  (PULSE_TICKS),
        .UNIT_CYC     (UNIT_CYC),
        .SEL_W        (SEL_W)
    ) tx_enc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .uart_txd (uart_txd),
        .width_sel(width_sel),
        .ir_txd   (ir_txd),
        .tx_busy  (tx_busy)
    );

    ir_sir_sync #(
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ir_rxd),
        .rise (ir_rise)
    );

    ir_sir_rx_dec #(
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) rx_dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .ir_rise    (ir_rise),
        .half_duplex(half_duplex),
        .tx_busy    (tx_busy),
        .uart_rxd   (uart_rxd)
    );

endmodule

// File: tb/ir_sir_codec_tb.sv
`timescale 1ns/1ps
module ir_sir_codec_tb_top;
    localparam int TP   = 4;      // clocks per tick
    localparam int CELL = 16 * TP;
    localparam int UNIT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uart_txd = 1'b1;
    logic [2:0] width_sel = 3'd0;
    logic       half_duplex = 1'b0;
    logic       loop_en = 1'b0;
    logic       ir_drv = 1'b0;
    logic       ir_txd, uart_rxd, ir_rxd, tick16;

    int cyc = 0;
    int tests = 0;
    int fails = 0;
    int nr = 0, nf = 0, lowcnt = 0;
    int rises [16];
    int falls [16];
    logic prev_tx = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    assign tick16 = (cyc % TP) == 0;
    assign ir_rxd = loop_en ? ir_txd : ir_drv;

    ir_sir_codec dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .uart_txd   (uart_txd),
        .width_sel  (width_sel),
        .half_duplex(half_duplex),
        .ir_rxd     (ir_rxd),
        .ir_txd     (ir_txd),
        .uart_rxd   (uart_rxd)
    );

    always @(negedge clk) cyc <= cyc + 1;

    // Edge monitor and watchdog
    always begin
        @(negedge clk);
        #2;
        if (ir_txd && !prev_tx) begin rises[nr % 16] = cyc; nr++; end
        if (!ir_txd && prev_tx) begin falls[nf % 16] = cyc; nf++; end
        prev_tx = ir_txd;
        if (!uart_rxd) lowcnt++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Send start + 8 data bits (LSB first) + stop; check pulses and optional loopback
    task automatic send_frame(input logic [7:0] d, input int rxmode);
        logic [9:0] bits;
        int start, nr0, nf0, zeros, w, zi;
        bits = {1'b1, d, 1'b0};
        w = (width_sel == 3'd0) ? 3 * TP : UNIT * int'(width_sel);
        step();
        while ((cyc % TP) != 0) step();
        start = cyc; nr0 = nr; nf0 = nf; zeros = 0;
        for (int k = 0; k < 10; k++) begin
            uart_txd = bits[k];
            if (!bits[k]) zeros++;
            for (int i = 0; i < CELL; i++) begin
                if (rxmode == 1 && i == 32)  // R10
                    check(uart_rxd == bits[k], "R10 loopback mid-cell", int'(uart_rxd), int'(bits[k]));
                if (rxmode == 2 && i == 32)  // R9
                    check(uart_rxd == 1'b1, "R9 echo blanked", int'(uart_rxd), 1);
                step();
            end
        end
        uart_txd = 1'b1;
        for (int i = 0; i < 2 * CELL; i++) step();
        // R3: one pulse per zero cell only
        check((nr - nr0) == zeros, "R3 pulse count", nr - nr0, zeros);
        zi = 0;
        for (int k = 0; k < 10; k++) begin
            if (!bits[k] && zi < (nr - nr0) && zi < (nf - nf0)) begin
                // R2: edge one clock after the cell's first tick
                check(rises[(nr0 + zi) % 16] == start + CELL * k + 1, "R2 pulse start",
                      rises[(nr0 + zi) % 16], start + CELL * k + 1);
                if (width_sel == 3'd0)  // R4
                    check(falls[(nf0 + zi) % 16] - rises[(nr0 + zi) % 16] == w, "R4 3/16 width",
                          falls[(nf0 + zi) % 16] - rises[(nr0 + zi) % 16], w);
                else  // R5
                    check(falls[(nf0 + zi) % 16] - rises[(nr0 + zi) % 16] == w, "R5 fixed width",
                          falls[(nf0 + zi) % 16] - rises[(nr0 + zi) % 16], w);
                zi++;
            end
        end
    endtask

    // Drive a receive pulse of w clocks, optionally a second one at offset 'second'
    task automatic rx_pulse(input int w, input int second);
        int t0, d, lim;
        step();
        t0 = cyc;
        ir_drv = 1'b1;
        lim = (second > 0) ? second + 80 : 80;
        for (int n = 0; n < lim; n++) begin
            step();
            d = cyc - t0;
            if (d == w) ir_drv = 1'b0;
            if (second > 0 && d == second) ir_drv = 1'b1;
            if (second > 0 && d == second + w) ir_drv = 1'b0;
            if (d == 2) check(uart_rxd == 1'b1, "R6 not yet low", int'(uart_rxd), 1);
            if (d == 3) begin
                if (w == 1) check(uart_rxd == 1'b0, "R7 short pulse decoded", int'(uart_rxd), 0);
                else        check(uart_rxd == 1'b0, "R6 low after 3 edges", int'(uart_rxd), 0);
            end
            if (second == 0 && d == 63) check(uart_rxd == 1'b0, "R6 window held", int'(uart_rxd), 0);
            if (second == 0 && d == 68) check(uart_rxd == 1'b1, "R6 window ended", int'(uart_rxd), 1);
            if (second > 0 && d == second + 60) check(uart_rxd == 1'b0, "R8 window restarted", int'(uart_rxd), 0);
            if (second > 0 && d == second + 68) check(uart_rxd == 1'b1, "R8 restarted window ended", int'(uart_rxd), 1);
        end
    endtask

    initial begin
        int lc0;
        for (int i = 0; i < 5; i++) step();
        // R1
        check(ir_txd == 1'b0, "R1 ir_txd in reset", int'(ir_txd), 0);
        check(uart_rxd == 1'b1, "R1 uart_rxd in reset", int'(uart_rxd), 1);
        rst_n = 1'b1;
        step();
        check(ir_txd == 1'b0, "R1 ir_txd after reset", int'(ir_txd), 0);
        check(uart_rxd == 1'b1, "R1 uart_rxd after reset", int'(uart_rxd), 1);

        // 3/16 mode sweep
        width_sel = 3'd0;
        send_frame(8'h00, 0);
        send_frame(8'hFF, 0);
        send_frame(8'h55, 0);
        send_frame(8'hAA, 0);
        for (int i = 0; i < 12; i++) send_frame(8'(i * 29 + 3), 0);

        // Fixed-width codes
        for (int m = 1; m < 8; m++) begin
            width_sel = 3'(m);
            send_frame(8'h00, 0);
            send_frame(8'hA5, 0);
            send_frame(8'h5A, 0);
            send_frame(8'hFF, 0);
        end

        // Receive path
        width_sel = 3'd0;
        rx_pulse(1, 0);
        rx_pulse(2, 0);
        rx_pulse(5, 0);
        rx_pulse(20, 0);
        rx_pulse(3, 40);

        // Half duplex: own echo blanked
        half_duplex = 1'b1;
        loop_en = 1'b1;
        lc0 = lowcnt;
        send_frame(8'h3C, 2);
        send_frame(8'h00, 2);
        check(lowcnt == lc0, "R9 no low cycles during echo", lowcnt - lc0, 0);

        // Full duplex loopback decode
        half_duplex = 1'b0;
        send_frame(8'h3C, 1);
        send_frame(8'hB6, 1);
        send_frame(8'h00, 1);
        loop_en = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule